// File: doc/BRIEF.md
# Step-by-Step Binary BCH Bit Corrector

This block is the final stage of a streaming step-by-step decoder for binary BCH codes that correct two or three errors. Received bits enter serially. The block holds each bit in a delay line for as long as the upstream syndrome and determinant pipeline takes to produce its decision vectors. For every bit position it then decides whether that bit is wrong and inverts it on the way out. The decision uses only two vectors of zero-test bits. The first is a reference vector taken once per word from the unmodified syndromes. The second is a trial vector computed with the current bit tentatively inverted.

Each decision vector maps to an error-count class. A bit is inverted exactly when inverting it moves the word one class lower. The last bit of every word, the low-order check bit, leaves the block unchanged. The upstream pipeline uses that bit's slot to load the reference vector of the next word, so words can follow each other with no idle cycle. The decision logic depends only on the correction capability `T`. The code length `N` and field degree `M` set only the delay.

Upstream contract: the trial vector for the bit received in cycle `a` is presented in cycle `a + DLY - CL - 1`. Here `DLY` is the total delay and `CL` is the corrector latency (1 for `T`=2, 2 for `T`=3). The reference vector of a word is presented, with `h_first` high, in the slot of the bit just before that word's first bit.

Top module: `sbs_bch_corrector`

## Requirements
- R1: With `T`=2 a vector `{h2,h1}` (bit 0 = h1) is in class 0 when 2'b11, class 1 when 2'b10 and class 2 when 2'b00; 2'b01 belongs to no class. A bit is inverted when the reference class is k (k ≥ 1) and the trial class is k-1.
- R2: With `T`=3 a vector `{h3,h2,h1}` is in class 0 when 3'b111, class 1 when 3'b110, class 2 when 3'b100, and class 3 when 3'b001 or 3'b000. Both members of class 3 lead to the same decisions, and the inversion rule of R1 applies.
- R3: A vector outside every class never causes an inversion. A word with more than `T` errors streams through without any stall or gap.
- R4: The bit in position `N`-1 of a word (counted from the cycle with `rx_sof` high, which is position 0) is output exactly as received, even if a correcting trial vector is presented in its slot.
- R5: The reference vector is captured only in a slot with `h_valid` and `h_first` both high, and is held until the next such slot. The value on `h_ref` in any other slot has no effect.
- R6: A bit received in cycle `a` appears on `dout_bit` in cycle `a + DLY`, where `DLY` = `N`+6`M`+2 for `T`=2 and `N`+9`M`+3 for `T`=3.
- R7: `dout_valid` equals `rx_valid` delayed by `DLY` cycles, so back-to-back words leave back to back. `dout_bit` is 0 whenever `dout_valid` is 0.
- R8: While `rst_n` is low and right after it, `dout_valid` and `dout_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received serial bit, highest-degree coefficient first |
| rx_valid | input | 1 | `rx_bit` carries a code bit this cycle |
| rx_sof | input | 1 | First bit of a word |
| h_valid | input | 1 | A decision vector is present this cycle |
| h_first | input | 1 | This slot loads the reference vector of the next word |
| h_ref | input | T | Reference decision vector, bit 0 = first zero test |
| h_trial | input | T | Trial decision vector for the aligned bit |
| dout_bit | output | 1 | Corrected serial bit |
| dout_valid | output | 1 | `dout_bit` carries a code bit |

## Verification
Two events can fall in the same cycle. The check bit of one word leaves the block raw while the reference vector of the next word is loaded. For `T`=3, the trial decision for that word's second-last bit is also still in the stage register at that moment. The bench provokes this with back-to-back words of different weights: one word carries an error in position `N`-2 and is followed directly by a word of another class. The bench then judges the inverted second-last bit and the untouched check bit against its own encoder. At the end of each burst no next word follows. There the bench drives a correcting trial vector into the check-bit slot to show that position alone keeps that bit raw.

// File: rtl/sbs_bch_pkg.sv
package sbs_bch_pkg;

  typedef logic [2:0] cls_t;

  localparam cls_t CLS_NONE = 3'd7;

  // total decoding delay, in cycles, from received bit to corrected bit
  function automatic int unsigned decode_delay(int unsigned n, int unsigned m, int unsigned t);
    return (t == 2) ? (n + 6 * m + 2) : (n + 9 * m + 3);
  endfunction

  // register stages between the decision inputs and the correction flag
  function automatic int unsigned corr_latency(int unsigned t);
    return (t == 2) ? 1 : 2;
  endfunction

  // map a zero-test vector (bit 0 = first test) to an error-count class
  function automatic cls_t classify(logic [2:0] v, int unsigned t);
    cls_t c;
    if (t == 2) begin
      case (v[1:0])
        2'b11:   c = 3'd0;
        2'b10:   c = 3'd1;
        2'b00:   c = 3'd2;
        default: c = CLS_NONE;
      endcase
    end else begin
      case (v)
        3'b111:        c = 3'd0;
        3'b110:        c = 3'd1;
        3'b100:        c = 3'd2;
        3'b001, 3'b000: c = 3'd3;
        default:       c = CLS_NONE;
      endcase
    end
    return c;
  endfunction

  // inverting the bit lowers the class by exactly one
  function automatic logic steps_down(cls_t ref_c, cls_t trial_c);
    return (ref_c != CLS_NONE) && (trial_c != CLS_NONE) && (ref_c != 3'd0) &&
           (trial_c == cls_t'(ref_c - 3'd1));
  endfunction

endpackage

// File: rtl/sbs_delay_line.sv
module sbs_delay_line #(
  parameter int DEPTH = 40,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/sbs_word_pos.sv
module sbs_word_pos #(
  parameter int N = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic sof,
  output logic last
);

  localparam int PW = $clog2(N + 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_now;

  assign pos_now = sof ? '0 : pos_q + PW'(1);
  assign last    = valid && (pos_now == PW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     pos_q <= '0;
    else if (valid) pos_q <= pos_now;
  end

endmodule

// File: rtl/sbs_decide.sv
module sbs_decide
  import sbs_bch_pkg::*;
#(
  parameter int T = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         h_valid,
  input  logic         h_first,
  input  logic [T-1:0] h_ref,
  input  logic [T-1:0] h_trial,
  output logic         e_q,
  output logic [T-1:0] ref_q
);

  logic load_slot;
  logic trial_slot;
  cls_t ref_cls;
  cls_t trial_cls;

  assign load_slot  = h_valid & h_first;
  assign trial_slot = h_valid & ~h_first;
  assign ref_cls    = classify(3'(ref_q), T);
  assign trial_cls  = classify(3'(h_trial), T);

  always_ff @(posedge clk) begin
    if (!rst_n)         ref_q <= '0;
    else if (load_slot) ref_q <= h_ref;
  end

  generate
    if (T == 2) begin : g_one_stage
      always_ff @(posedge clk) begin
        if (!rst_n) e_q <= 1'b0;
        else        e_q <= trial_slot & steps_down(ref_cls, trial_cls);
      end
    end else begin : g_two_stage
      logic ok_s1;
      cls_t rc_s1;
      cls_t tc_s1;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ok_s1 <= 1'b0;
          rc_s1 <= CLS_NONE;
          tc_s1 <= CLS_NONE;
          e_q   <= 1'b0;
        end else begin
          ok_s1 <= trial_slot;
          rc_s1 <= ref_cls;
          tc_s1 <= trial_cls;
          e_q   <= ok_s1 & steps_down(rc_s1, tc_s1);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sbs_bch_corrector.sv
module sbs_bch_corrector
  import sbs_bch_pkg::*;
#(
  parameter int N = 15,
  parameter int M = 4,
  parameter int T = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_bit,
  input  logic         rx_valid,
  input  logic         rx_sof,
  input  logic         h_valid,
  input  logic         h_first,
  input  logic [T-1:0] h_ref,
  input  logic [T-1:0] h_trial,
  output logic         dout_bit,
  output logic         dout_valid
);

  localparam int DLY   = int'(decode_delay(N, M, T));
  localparam int DEPTH = DLY - 1;

  logic [2:0]   tap;
  logic         tap_bit;
  logic         tap_valid;
  logic         tap_sof;
  logic         tap_last;
  logic         e_q;
  logic [T-1:0] ref_q;
  logic         corr_apply;

  sbs_delay_line #(.DEPTH(DEPTH), .W(3)) u_line (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({rx_sof, rx_valid, rx_bit}),
    .dout (tap)
  );

  assign tap_bit   = tap[0];
  assign tap_valid = tap[1];
  assign tap_sof   = tap[2];

  sbs_word_pos #(.N(N)) u_pos (
    .clk  (clk),
    .rst_n(rst_n),
    .valid(tap_valid),
    .sof  (tap_sof),
    .last (tap_last)
  );

  sbs_decide #(.T(T)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .h_valid(h_valid),
    .h_first(h_first),
    .h_ref  (h_ref),
    .h_trial(h_trial),
    .e_q    (e_q),
    .ref_q  (ref_q)
  );

  assign corr_apply = e_q & tap_valid & ~tap_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_bit   <= 1'b0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= tap_valid;
      dout_bit   <= tap_valid & (tap_bit ^ corr_apply);
    end
  end

endmodule

// File: rtl/sbs_bch_corrector_chk.sv
module sbs_bch_corrector_chk
  import sbs_bch_pkg::*;
#(
  parameter int T = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         h_valid,
  input logic         h_first,
  input logic [T-1:0] h_ref,
  input logic [T-1:0] ref_q,
  input logic         e_q,
  input logic         tap_valid,
  input logic         tap_last,
  input logic         tap_bit,
  input logic         dout_bit,
  input logic         dout_valid
);

  localparam int CL = int'(corr_latency(T));

  // R4
  last_bit_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_valid && tap_last) |=> (dout_bit == $past(tap_bit)));

  // R5
  ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_first) |=> (ref_q == $past(h_ref)));

  // R5
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_valid && h_first) |=> $stable(ref_q));

  // R1
  corr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_q |-> ($past(h_valid, CL) && !$past(h_first, CL)));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid |=> dout_valid);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> !dout_bit);

endmodule

bind sbs_bch_corrector sbs_bch_corrector_chk #(.T(T)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .h_valid   (h_valid),
  .h_first   (h_first),
  .h_ref     (h_ref),
  .ref_q     (ref_q),
  .e_q       (e_q),
  .tap_valid (tap_valid),
  .tap_last  (tap_last),
  .tap_bit   (tap_bit),
  .dout_bit  (dout_bit),
  .dout_valid(dout_valid)
);

// File: tb/test_sbs_bch_corrector.sv
`timescale 1ns/1ps
module test_sbs_bch_corrector;

  localparam int N      = 15;
  localparam int M      = 4;
  localparam int CYC    = 800;
  localparam int NWORDS = 36;
  localparam int WD_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       rxb [2];
  logic       rxv [2];
  logic       rxs [2];
  logic       hv  [2];
  logic       hf  [2];
  logic [1:0] href_a, htr_a;
  logic [2:0] href_b, htr_b;
  logic       ob  [2];
  logic       ov  [2];

  sbs_bch_corrector #(.N(N), .M(M), .T(2)) i_sbs_bch_corrector (
    .clk(clk), .rst_n(rst_n), .rx_bit(rxb[0]), .rx_valid(rxv[0]), .rx_sof(rxs[0]),
    .h_valid(hv[0]), .h_first(hf[0]), .h_ref(href_a), .h_trial(htr_a),
    .dout_bit(ob[0]), .dout_valid(ov[0]));

  sbs_bch_corrector #(.N(N), .M(M), .T(3)) i_sbs_bch_corrector_t3 (
    .clk(clk), .rst_n(rst_n), .rx_bit(rxb[1]), .rx_valid(rxv[1]), .rx_sof(rxs[1]),
    .h_valid(hv[1]), .h_first(hf[1]), .h_ref(href_b), .h_trial(htr_b),
    .dout_bit(ob[1]), .dout_valid(ov[1]));

  // stimulus schedule and expected results, per instance and cycle
  logic       s_bit [2][CYC];
  logic       s_val [2][CYC];
  logic       s_sof [2][CYC];
  logic       s_hv  [2][CYC];
  logic       s_hf  [2][CYC];
  logic [2:0] s_href[2][CYC];
  logic [2:0] s_htr [2][CYC];
  logic       e_val [2][CYC];
  logic       e_bit [2][CYC];
  logic       e_chk [2][CYC];
  int         e_tag [2][CYC];
  int         v_tag [2][CYC];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  function automatic logic [14:0] encode(logic [14:0] msg, int deg, logic [15:0] g);
    logic [14:0] r;
    r = msg << deg;
    for (int i = 14; i >= deg; i--)
      if (r[i]) r = r ^ 15'(g << (i - deg));
    return (msg << deg) ^ r;
  endfunction

  // a decision vector of the class for k errors; k = t+1 gives one outside class t-1
  function automatic logic [2:0] rep(int k, int t);
    logic [2:0] v;
    if (t == 2) begin
      case (k)
        0: v = 3'b011;
        1: v = 3'b010;
        2: v = 3'b000;
        default: begin
          case ($urandom_range(0, 2))
            0: v = 3'b011;
            1: v = 3'b000;
            default: v = 3'b001;
          endcase
        end
      endcase
    end else begin
      case (k)
        0: v = 3'b111;
        1: v = 3'b110;
        2: v = 3'b100;
        3: v = ($urandom_range(0, 1) != 0) ? 3'b001 : 3'b000;
        default: begin
          v = 3'(($urandom_range(0, 6) + 5) % 8);
          if (v == 3'b100) v = 3'b011;
        end
      endcase
    end
    return v;
  endfunction

  function automatic string tag_str(int tag, int t);
    case (tag)
      1: return (t == 2) ? "R1 R5" : "R2 R5";
      3: return "R3 R7";
      4: return "R4";
      6: return "R6";
      8: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic place_word(int u, int s, logic [14:0] emask, bit next_follows);
    int t, deg, k, dly, lead, ww, a, c;
    logic [15:0] g;
    logic [14:0] msg, cw;
    logic rb;
    t    = (u == 0) ? 2 : 3;
    deg  = (t == 2) ? 8 : 10;
    g    = (t == 2) ? 16'h01D1 : 16'h0537;
    k    = N - deg;
    dly  = (t == 2) ? N + 6 * M + 2 : N + 9 * M + 3;       // R6
    lead = dly - ((t == 2) ? 1 : 2) - 1;
    msg  = 15'($urandom) & 15'((1 << k) - 1);
    cw   = encode(msg, deg, g);
    ww   = $countones(emask);
    for (int p = 0; p < N; p++) begin
      a  = s + p;
      rb = cw[14-p] ^ emask[p];
      s_bit[u][a] = rb;
      s_val[u][a] = 1'b1;
      s_sof[u][a] = (p == 0);
      e_val[u][a+dly] = 1'b1;
      if (ww > t) v_tag[u][a+dly] = 3;
      if (p == N - 1) begin
        e_bit[u][a+dly] = rb; e_chk[u][a+dly] = 1'b1; e_tag[u][a+dly] = 4;
      end else if (ww <= t) begin
        e_bit[u][a+dly] = cw[14-p]; e_chk[u][a+dly] = 1'b1;
        e_tag[u][a+dly] = emask[p] ? 1 : 6;
      end
    end
    c = s - 1 + lead;
    s_hv[u][c] = 1'b1; s_hf[u][c] = 1'b1;
    s_href[u][c] = (ww <= t) ? rep(ww, t) : 3'($urandom);
    s_htr[u][c]  = s_href[u][c];
    for (int p = 0; p < N - 1; p++) begin
      c = s + p + lead;
      s_hv[u][c] = 1'b1; s_hf[u][c] = 1'b0;
      s_href[u][c] = 3'($urandom);                         // R5: ignored outside load slots
      if (ww > t)          s_htr[u][c] = 3'($urandom);
      else if (emask[p])   s_htr[u][c] = rep(ww - 1, t);
      else                 s_htr[u][c] = rep(ww + 1, t);
    end
    if (!next_follows && ww >= 1 && ww <= t) begin
      c = s + N - 1 + lead;                                 // R4: tempting vector on check bit
      s_hv[u][c] = 1'b1; s_hf[u][c] = 1'b0;
      s_href[u][c] = 3'($urandom);
      s_htr[u][c] = rep(ww - 1, t);
    end
  endtask

  function automatic logic [14:0] rand_mask(int w);
    logic [14:0] m;
    int pos;
    m = '0;
    for (int i = 0; i < w; i++) begin
      pos = $urandom_range(0, N - 1);
      while (m[pos]) pos = (pos + 1) % N;
      m[pos] = 1'b1;
    end
    return m;
  endfunction

  task automatic build(int u);
    int t, s;
    logic [14:0] em;
    t = (u == 0) ? 2 : 3;
    s = 6;
    for (int w = 0; w < NWORDS; w++) begin
      if (w == 20) s = s + 9;
      case (w)
        0:  em = '0;
        1:  em = 15'h0001;                                  // first bit in error
        2:  em = 15'h2000;                                  // second-last bit in error
        3:  em = 15'h4000;                                  // check bit in error
        4:  em = (t == 2) ? 15'h2001 : 15'h2081;            // full weight
        5:  em = (t == 2) ? 15'h0222 : 15'h0A22;            // over the limit
        6:  em = 15'h2000;                                  // followed by another class
        7:  em = rand_mask(t);
        19: em = 15'h4008;                                  // end of burst
        35: em = 15'h0010;
        default: em = rand_mask($urandom_range(0, t));
      endcase
      place_word(u, s, em, (w != 19) && (w != NWORDS - 1));
      s = s + N;
    end
  endtask

  task automatic check_out(int u, int c);
    int t;
    t = (u == 0) ? 2 : 3;
    n_chk++;
    if (ov[u] !== e_val[u][c]) begin
      n_fail++;
      $display("FAIL %s inst %0d cycle %0d: dout_valid actual %0b expected %0b",
               tag_str(v_tag[u][c], t), u, c, ov[u], e_val[u][c]);
    end
    if (e_val[u][c] && e_chk[u][c]) begin
      n_chk++;
      if (ob[u] !== e_bit[u][c]) begin
        n_fail++;
        $display("FAIL %s inst %0d cycle %0d: dout_bit actual %0b expected %0b",
                 tag_str(e_tag[u][c], t), u, c, ob[u], e_bit[u][c]);
      end
    end else if (!e_val[u][c]) begin
      n_chk++;
      if (ob[u] !== 1'b0) begin
        n_fail++;
        $display("FAIL %s inst %0d cycle %0d: idle dout_bit actual %0b expected 0",
                 tag_str(v_tag[u][c], t), u, c, ob[u]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int u = 0; u < 2; u++) begin
      for (int c = 0; c < CYC; c++) begin
        s_bit[u][c] = 1'b0; s_val[u][c] = 1'b0; s_sof[u][c] = 1'b0;
        s_hv[u][c] = 1'b0;  s_hf[u][c] = 1'b0;
        s_href[u][c] = '0;  s_htr[u][c] = '0;
        e_val[u][c] = 1'b0; e_bit[u][c] = 1'b0; e_chk[u][c] = 1'b0;
        e_tag[u][c] = 7;    v_tag[u][c] = (c < 5) ? 8 : 7;   // R8 during reset
      end
      build(u);
    end
    for (int u = 0; u < 2; u++) begin
      rxb[u] = 1'b0; rxv[u] = 1'b0; rxs[u] = 1'b0; hv[u] = 1'b0; hf[u] = 1'b0;
    end
    href_a = '0; htr_a = '0; href_b = '0; htr_b = '0;
    for (int c = 0; c < CYC; c++) begin
      @(negedge clk);
      if (c == 4) rst_n = 1'b1;
      for (int u = 0; u < 2; u++) begin
        rxb[u] = s_bit[u][c]; rxv[u] = s_val[u][c]; rxs[u] = s_sof[u][c];
        hv[u]  = s_hv[u][c];  hf[u]  = s_hf[u][c];
      end
      href_a = s_href[0][c][1:0]; htr_a = s_htr[0][c][1:0];
      href_b = s_href[1][c];      htr_b = s_htr[1][c];
      if (c > 0) begin
        check_out(0, c);
        check_out(1, c);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(WD_CYC * 5.0);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: run actual unfinished expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule